// File: doc/BRIEF.md
# Robbed-Bit Signaling Extractor with Integration Debounce

This block pulls robbed-bit ABCD signaling out of a T1 receive stream that is already frame-aligned. Each octet bit arrives with its channel index, its bit position and its frame number within the 24-frame multiframe. The signaling bit of a channel is the last bit of its octet in every sixth frame. The block collects these bits per channel into a 2-state, 4-state or 16-state word. A word is accepted only when two successive completed samples agree. Each channel keeps its own accepted state.

An accepted change marks the channel as changed and, when enabled, raises a sticky interrupt flag. A read port returns the state and the changed mark of any channel. An acknowledge clears the flag and the changed mark of the channel on the read port. Sampling can be frozen on request or while frame alignment is lost. During a freeze the stored states and the interrupt stay as they are.

Top module: `rbs_extract`

## Requirements
- R1: After reset every channel state is 0000, every changed mark is 0 and `irq_o` is 0.
- R2: Only a valid bit at position 7 (the last bit of the octet) in frames 6, 12, 18 or 24 is used. Bits at any other position or in any other frame have no effect on any output.
- R3: When `mode_i` is 2 or 3 (16-state), the bit in frame 6 is A, in frame 12 is B, in frame 18 is C and in frame 24 is D. The word completes at frame 24. The state is read as bit3=A, bit2=B, bit1=C, bit0=D.
- R4: When `mode_i` is 1 (4-state), frames 6 and 18 carry A and frames 12 and 24 carry B. A word completes at frames 12 and 24, so there are two samples per multiframe. The state is {A,B,0,0}.
- R5: When `mode_i` is 0 (2-state), every signaling frame completes a word {A,0,0,0}.
- R6: A completed word replaces a channel's state only if it equals the previous completed word of that channel. A single differing sample leaves the state unchanged.
- R7: Channels are independent. A sample of one channel never alters another channel's state.
- R8: An accepted word that differs from the stored state sets that channel's changed mark. It sets `irq_o` only while `irq_en_i` is 1. A word equal to the stored state sets neither.
- R9: `ack_i` clears `irq_o` and the changed mark of channel `rd_chan_i`.
- R10: While `frz_man_i` or `align_lost_i` is 1, `frozen_o` is 1 and samples are ignored: no state, changed mark or interrupt changes. Sampling resumes when both are low.
- R11: The state, changed mark and interrupt reflect a sample or acknowledge one clock after the edge that captures it. `rd_state_o` and `rd_chg_o` follow `rd_chan_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 = 2-state, 1 = 4-state, 2/3 = 16-state |
| bit_vld_i | input | 1 | Receive bit is valid this cycle |
| bit_i | input | 1 | Receive data bit |
| bit_pos_i | input | 3 | Bit position inside the channel octet (7 = last) |
| chan_i | input | 5 | Channel of the current bit (0..23) |
| frame_i | input | 5 | Frame number within the multiframe (1..24) |
| frz_man_i | input | 1 | Manual freeze request |
| align_lost_i | input | 1 | Frame alignment lost (automatic freeze) |
| irq_en_i | input | 1 | Interrupt enable |
| ack_i | input | 1 | Read acknowledge |
| rd_chan_i | input | 5 | Channel selected on the read port |
| rd_state_o | output | 4 | Accepted ABCD state of the selected channel |
| rd_chg_o | output | 1 | Changed mark of the selected channel |
| irq_o | output | 1 | Sticky state-change interrupt |
| frozen_o | output | 1 | Sampling is frozen |

## Verification
A completing signaling bit or an acknowledge presented before a rising edge shows up on the state, the changed mark and the interrupt just after that edge. The read port and the freeze indicator are combinational and settle within the same cycle. The bench drives every input on the falling edge. One nanosecond after each rising edge it compares all outputs with a behavioural model that updated on that same edge, so a one-cycle slip in any result is caught. Directed checks move the read channel while the stream is idle and sample after the combinational path has settled.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam int ABCD_W = 4;
   typedef logic [ABCD_W-1:0] abcd_t;
   typedef enum logic [1:0] {
      SIG_2ST  = 2'b00,
      SIG_4ST  = 2'b01,
      SIG_16ST = 2'b10
   } sig_mode_e;
endpackage

// File: rtl/rbs_tap.sv
// Decides whether the current bit is a signaling bit and where it lands in the word.
module rbs_tap
   import rbs_pkg::*;
#(
   parameter int FRAMES      = 24,
   parameter int SIG_PERIOD  = 6,
   parameter int BITS_PER_CH = 8,
   parameter int POS_W       = $clog2(BITS_PER_CH),
   parameter int FR_W        = $clog2(FRAMES + 1)
) (
   input  logic             bit_vld_i,
   input  logic [POS_W-1:0] bit_pos_i,
   input  logic [FR_W-1:0]  frame_i,
   input  logic [1:0]       mode_i,
   input  logic             hold_i,
   output logic             take_o,
   output logic [1:0]       slot_o,
   output logic             done_o
);
   initial begin
      assert (FRAMES == 4 * SIG_PERIOD) else $error("FRAMES must hold four signaling frames");
      assert (BITS_PER_CH >= 2) else $error("BITS_PER_CH too small");
   end

   sig_mode_e        md;
   logic             is_sig;
   logic             at_lsb;
   logic [FR_W-1:0]  quo;
   logic [1:0]       grp;

   assign md     = sig_mode_e'(mode_i);
   assign at_lsb = (bit_pos_i == POS_W'(BITS_PER_CH - 1));
   assign is_sig = (frame_i != '0) && (frame_i <= FR_W'(FRAMES))
                   && ((frame_i % FR_W'(SIG_PERIOD)) == '0);
   assign quo    = (frame_i / FR_W'(SIG_PERIOD)) - FR_W'(1);
   assign grp    = quo[1:0];
   assign take_o = bit_vld_i && !hold_i && is_sig && at_lsb;

   always_comb begin
      case (md)
         SIG_2ST: begin
            slot_o = 2'd0;
            done_o = 1'b1;
         end
         SIG_4ST: begin
            slot_o = {1'b0, grp[0]};
            done_o = grp[0];
         end
         default: begin
            slot_o = grp;
            done_o = (grp == 2'd3);
         end
      endcase
   end
endmodule

// File: rtl/rbs_cell.sv
// One channel: word assembly, two-sample integration, stored state and changed mark.
module rbs_cell
   import rbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_i,
   input  logic [1:0] slot_i,
   input  logic       done_i,
   input  logic       bit_i,
   input  logic [1:0] mode_i,
   input  logic       clr_i,
   output abcd_t      state_o,
   output logic       chg_o,
   output logic       evt_o
);
   logic [2:0] acc_q;
   abcd_t      prev_q;
   logic       pv_q;
   abcd_t      state_q;
   abcd_t      word;

   always_comb begin
      case (sig_mode_e'(mode_i))
         SIG_2ST: word = {bit_i, 3'b000};
         SIG_4ST: word = {acc_q[2], bit_i, 2'b00};
         default: word = {acc_q, bit_i};
      endcase
   end

   assign evt_o   = take_i && done_i && pv_q && (word == prev_q) && (word != state_q);
   assign state_o = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         prev_q  <= '0;
         pv_q    <= 1'b0;
         state_q <= '0;
         chg_o   <= 1'b0;
      end else begin
         if (take_i && !done_i) begin
            case (slot_i)
               2'd0:    acc_q[2] <= bit_i;
               2'd1:    acc_q[1] <= bit_i;
               2'd2:    acc_q[0] <= bit_i;
               default: acc_q    <= acc_q;
            endcase
         end
         if (take_i && done_i) begin
            prev_q <= word;
            pv_q   <= 1'b1;
         end
         if (evt_o) state_q <= word;
         if (evt_o)      chg_o <= 1'b1;
         else if (clr_i) chg_o <= 1'b0;
      end
   end

   AST_STATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_q) |-> $past(take_i && done_i)); // R6
   AST_STATE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_q) |-> (pv_q && prev_q == state_q)); // R6
   AST_CHG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_q) |-> chg_o); // R8
endmodule

// File: rtl/rbs_extract.sv
module rbs_extract
   import rbs_pkg::*;
#(
   parameter int NCH         = 24,
   parameter int FRAMES      = 24,
   parameter int SIG_PERIOD  = 6,
   parameter int BITS_PER_CH = 8,
   parameter int CH_W        = $clog2(NCH),
   parameter int POS_W       = $clog2(BITS_PER_CH),
   parameter int FR_W        = $clog2(FRAMES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   input  logic [POS_W-1:0] bit_pos_i,
   input  logic [CH_W-1:0]  chan_i,
   input  logic [FR_W-1:0]  frame_i,
   input  logic             frz_man_i,
   input  logic             align_lost_i,
   input  logic             irq_en_i,
   input  logic             ack_i,
   input  logic [CH_W-1:0]  rd_chan_i,
   output logic [3:0]       rd_state_o,
   output logic             rd_chg_o,
   output logic             irq_o,
   output logic             frozen_o
);
   localparam int FLAT_W = NCH * ABCD_W;

   initial begin
      assert (NCH >= 2) else $error("NCH must be at least 2");
      assert ((1 << CH_W) >= NCH) else $error("CH_W too narrow for NCH");
   end

   logic              hold;
   logic              take;
   logic [1:0]        slot;
   logic              done;
   abcd_t             st [NCH];
   logic [FLAT_W-1:0] st_flat;
   logic [NCH-1:0]    chg_vec;
   logic [NCH-1:0]    evt_vec;
   logic              any_evt;

   assign hold     = frz_man_i | align_lost_i;
   assign frozen_o = hold;

   rbs_tap #(
      .FRAMES(FRAMES), .SIG_PERIOD(SIG_PERIOD), .BITS_PER_CH(BITS_PER_CH),
      .POS_W(POS_W), .FR_W(FR_W)
   ) u_tap (
      .bit_vld_i(bit_vld_i), .bit_pos_i(bit_pos_i), .frame_i(frame_i),
      .mode_i(mode_i), .hold_i(hold),
      .take_o(take), .slot_o(slot), .done_o(done)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic sel;
      logic clr;
      assign sel = take && (chan_i == CH_W'(g));
      assign clr = ack_i && (rd_chan_i == CH_W'(g));
      rbs_cell u_cell (
         .clk(clk), .rst_n(rst_n), .take_i(sel), .slot_i(slot), .done_i(done),
         .bit_i(bit_i), .mode_i(mode_i), .clr_i(clr),
         .state_o(st[g]), .chg_o(chg_vec[g]), .evt_o(evt_vec[g])
      );
      assign st_flat[g*ABCD_W +: ABCD_W] = st[g];
   end

   assign any_evt = |evt_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   irq_o <= 1'b0;
      else if (any_evt && irq_en_i) irq_o <= 1'b1;
      else if (ack_i)               irq_o <= 1'b0;
   end

   assign rd_state_o = (int'(rd_chan_i) < NCH) ? st[rd_chan_i] : '0;
   assign rd_chg_o   = (int'(rd_chan_i) < NCH) ? chg_vec[rd_chan_i] : 1'b0;

   AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(st_flat)); // R10
   AST_HOLD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !irq_o) |=> !irq_o); // R10
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(any_evt && irq_en_i)); // R8
   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !any_evt) |=> !irq_o); // R9
   AST_ONE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_vec)); // R7
endmodule

// File: tb/rbs_extract_tb.sv
module rbs_extract_tb;
   localparam int NCH = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd2;
   logic       bit_vld = 1'b0;
   logic       bit_d = 1'b0;
   logic [2:0] pos = '0;
   logic [4:0] chan = '0;
   logic [4:0] frame = '0;
   logic       frz = 1'b0;
   logic       lost = 1'b0;
   logic       irq_en = 1'b0;
   logic       ack = 1'b0;
   logic [4:0] rd_chan = '0;
   logic [3:0] rd_state;
   logic       rd_chg;
   logic       irq;
   logic       frozen;

   int nchk = 0;
   int nerr = 0;
   bit fin = 1'b0;
   int tx [NCH];

   int m_state [NCH];
   int m_prev [NCH];
   int m_pv [NCH];
   int m_a [NCH];
   int m_b [NCH];
   int m_c [NCH];
   int m_chg [NCH];
   int m_irq;

   always #2 clk = ~clk;

   rbs_extract u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .bit_vld_i(bit_vld), .bit_i(bit_d),
      .bit_pos_i(pos), .chan_i(chan), .frame_i(frame), .frz_man_i(frz),
      .align_lost_i(lost), .irq_en_i(irq_en), .ack_i(ack), .rd_chan_i(rd_chan),
      .rd_state_o(rd_state), .rd_chg_o(rd_chg), .irq_o(irq), .frozen_o(frozen)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference, updated on the same edge as the design
   always @(posedge clk) begin
      int ev;
      int w;
      int k;
      bit dn;
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_state[i] = 0; m_prev[i] = 0; m_pv[i] = 0;
            m_a[i] = 0; m_b[i] = 0; m_c[i] = 0; m_chg[i] = 0;
         end
         m_irq = 0;
      end else begin
         ev = -1;
         if (bit_vld && pos == 3'd7 && !frz && !lost && frame >= 6 && frame <= 24
             && frame % 6 == 0) begin
            k = frame / 6 - 1;
            dn = 1'b0;
            w = 0;
            if (mode == 2'd0) begin
               dn = 1'b1; w = bit_d * 8;
            end else if (mode == 2'd1) begin
               if (k % 2 == 0) m_a[chan] = bit_d;
               else begin dn = 1'b1; w = m_a[chan] * 8 + bit_d * 4; end
            end else begin
               if (k == 0) m_a[chan] = bit_d;
               else if (k == 1) m_b[chan] = bit_d;
               else if (k == 2) m_c[chan] = bit_d;
               else begin
                  dn = 1'b1;
                  w = m_a[chan] * 8 + m_b[chan] * 4 + m_c[chan] * 2 + bit_d;
               end
            end
            if (dn) begin
               if (m_pv[chan] == 1 && w == m_prev[chan] && w != m_state[chan]) begin
                  m_state[chan] = w;
                  ev = chan;
               end
               m_prev[chan] = w;
               m_pv[chan] = 1;
            end
         end
         if (ack) m_chg[rd_chan] = 0;
         if (ev >= 0) m_chg[ev] = 1;
         if (ev >= 0 && irq_en) m_irq = 1;
         else if (ack) m_irq = 0;
      end
   end

   // cycle-by-cycle comparison (R11)
   always begin
      @(posedge clk);
      #1;
      if (rst_n && !fin) begin
         chk("R11 state vs model", rd_state, m_state[rd_chan]);
         chk("R11 changed vs model", rd_chg, m_chg[rd_chan]);
         chk("R11 irq vs model", irq, m_irq);
         chk("R10 frozen vs model", frozen, int'(frz | lost));
      end
   end

   function automatic bit sig_bit(input int c, input int f);
      int k;
      k = f / 6 - 1;
      if (mode == 2'd0) return tx[c][3];
      if (mode == 2'd1) return (k % 2 == 0) ? tx[c][3] : tx[c][2];
      return tx[c][3 - k];
   endfunction

   task automatic send_mf();
      for (int f = 1; f <= 24; f++)
         for (int c = 0; c < NCH; c++)
            for (int p = 0; p < 8; p++) begin
               @(negedge clk);
               bit_vld = 1'b1;
               frame = 5'(f);
               chan = 5'(c);
               pos = 3'(p);
               if (p == 7 && f % 6 == 0) bit_d = sig_bit(c, f);
               else bit_d = ~sig_bit(c, 6) ^ 1'((p + c + f) & 1);
            end
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic peek(input int c, input string tag, input int exp_st, input int exp_chg);
      @(negedge clk);
      rd_chan = 5'(c);
      #1;
      chk({tag, " state"}, rd_state, exp_st);
      if (exp_chg >= 0) chk({tag, " changed"}, rd_chg, exp_chg);
   endtask

   task automatic do_ack(input int c);
      @(negedge clk);
      rd_chan = 5'(c);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek(0, "R1 ch0", 0, 0);
      peek(23, "R1 ch23", 0, 0);
      chk("R1 irq", irq, 0);

      // R3 16-state, R2 noise on other bits, R6 needs two multiframes
      mode = 2'd2;
      irq_en = 1'b1;
      for (int c = 0; c < NCH; c++) tx[c] = (c ^ 5) & 15;
      send_mf();
      peek(3, "R6 single sample", 0, 0);
      send_mf();
      peek(3, "R3 R2 ch3", 6, 1);
      peek(10, "R7 ch10", 15, 1);
      peek(5, "R8 equal word", 0, 0);
      chk("R8 irq set", irq, 1);

      // R9 acknowledge
      do_ack(3);
      peek(3, "R9 ch3 cleared", 6, 0);
      peek(4, "R9 ch4 kept", 1, 1);
      chk("R9 irq cleared", irq, 0);

      // R6 one-sample glitch rejected
      tx[7] = 15;
      send_mf();
      tx[7] = 7 ^ 5;
      send_mf();
      peek(7, "R6 glitch", 2, -1);
      chk("R6 no irq", irq, 0);

      // R10 manual then automatic freeze
      for (int c = 0; c < NCH; c++) tx[c] = 12;
      frz = 1'b1;
      send_mf();
      send_mf();
      peek(0, "R10 manual freeze", 5, -1);
      chk("R10 frozen flag", frozen, 1);
      chk("R10 no irq", irq, 0);
      frz = 1'b0;
      lost = 1'b1;
      send_mf();
      peek(0, "R10 align lost", 5, -1);
      lost = 1'b0;
      send_mf();
      send_mf();
      peek(0, "R10 resume", 12, 1);
      chk("R10 resume irq", irq, 1);

      // R4 4-state: two samples per multiframe
      do_ack(0);
      mode = 2'd1;
      for (int c = 0; c < NCH; c++) tx[c] = (c & 1) * 8 + ((c >> 1) & 1) * 4;
      send_mf();
      peek(2, "R4 ch2", 4, -1);
      peek(1, "R4 ch1", 8, -1);

      // R5 2-state with interrupt masked (R8)
      do_ack(0);
      irq_en = 1'b0;
      mode = 2'd0;
      for (int c = 0; c < NCH; c++) tx[c] = ((c >> 2) & 1) * 8;
      send_mf();
      peek(4, "R5 ch4", 8, 1);
      peek(3, "R5 ch3", 0, -1);
      chk("R8 masked irq", irq, 0);

      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL R11 watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule